// File: doc/BRIEF.md
# Cassette Card Bus Interface

This block sits on an 8-bit microprocessor bus and serves a cassette card. It claims a 4 KB window selected by the top address nibble. In that window, two 256-byte pages serve one shared program ROM: a code page and an I/O page. Any access to the I/O page, read or write, flips the flip-flop that drives the tape output line. That lets software build a waveform by timing its accesses.

The tape input is not read through a status register. In the upper half of the I/O page, a high input level forces ROM address bit 0 to zero, while a low level lets it through. A read of an odd location therefore returns one of two adjacent ROM bytes, and software finds tape edges by comparing successive reads. The input is asynchronous and passes through a synchroniser before it can steer the address. The ROM is a synchronous array. A separate load port fills it before use, and bus writes never alter it.

Top module: `tape_card_if`

## Requirements
- R1: The block drives read data (`bus_drive` high) only for reads whose top nibble is hex C and whose bits 11..8 select page 0 (I/O) or page 1 (code); every other address yields no drive and no tape toggle.
- R2: A read of the code page returns the ROM byte at the address's low byte.
- R3: A read at I/O page offsets 00..7F returns the ROM byte at the low byte, whatever the tape input level.
- R4: A read at I/O page offsets 80..FF returns the ROM byte at the low byte with bit 0 cleared when the synchronised tape input is high, and the unmodified low byte when it is low.
- R5: Each bus access to the I/O page, read or write, inverts `tape_out` exactly once, even when `bus_req` is held for several cycles; code page accesses leave it unchanged.
- R6: Bus writes never alter ROM contents and never raise `bus_drive`.
- R7: While reset is asserted, `tape_out` and `bus_drive` are low.
- R8: The tape input reaches the address logic through a two-stage synchroniser: a read sampled on the first clock edge after the input changes still sees the old level.
- R9: Read data and `bus_drive` appear in the cycle after the edge that samples the request, and they are refreshed on every cycle the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access in progress; one bus cycle is a run of high cycles |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | Bus address |
| bus_rdata | output | 8 | ROM read data |
| bus_drive | output | 1 | Read data valid and driven onto the bus |
| tape_in | input | 1 | Digital tape input level, asynchronous |
| tape_out | output | 1 | Tape output line |
| rom_ld_en | input | 1 | ROM load strobe |
| rom_ld_addr | input | 8 | ROM load address |
| rom_ld_data | input | 8 | ROM load byte |

## Verification
The assertions assume that `bus_req` stays low while reset is asserted. They also assume that address and write-enable stay stable while a request is held, so that a run of high cycles means one access. The stimulus changes address only between requests and leaves at least one idle cycle between accesses. It loads the ROM only while no bus access is in flight, and it changes `tape_in` at least three cycles before any read whose result depends on the new level. The one exception is the synchroniser-latency check, which deliberately issues the read right after the change.

// File: rtl/tape_card_pkg.sv
package tape_card_pkg;
   typedef struct packed {
      logic in_window;
      logic io_page;
      logic code_page;
      logic fold_zone;
   } tc_sel_t;
endpackage

// File: rtl/tape_card_sync.sv
module tape_card_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_sync = d_async;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d_async;
         end
         assign d_sync = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], d_async};
         end
         assign d_sync = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tape_card_decode.sv
module tape_card_decode
   import tape_card_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          ROM_AW    = 8,
   parameter logic [3:0]  CARD_ID   = 4'hC,
   parameter int          IO_PAGE   = 0,
   parameter int          CODE_PAGE = 1,
   parameter bit          FOLD_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              tape_lvl,
   output tc_sel_t           sel,
   output logic [ROM_AW-1:0] rom_addr
);
   localparam int PAGE_W = ADDR_W - 4 - ROM_AW;
   localparam logic [PAGE_W-1:0] IO_PG   = PAGE_W'(IO_PAGE);
   localparam logic [PAGE_W-1:0] CODE_PG = PAGE_W'(CODE_PAGE);

   logic [3:0]        nib;
   logic [PAGE_W-1:0] page;
   logic [ROM_AW-1:0] low;

   assign nib  = addr[ADDR_W-1 -: 4];
   assign page = addr[ROM_AW +: PAGE_W];
   assign low  = addr[ROM_AW-1:0];

   always_comb begin
      sel.in_window = (nib == CARD_ID);
      sel.io_page   = sel.in_window && (page == IO_PG);
      sel.code_page = sel.in_window && (page == CODE_PG);
      sel.fold_zone = sel.io_page && low[ROM_AW-1];
   end

   generate
      if (FOLD_EN) begin : g_fold
         always_comb begin
            rom_addr = low;
            if (sel.fold_zone && tape_lvl) rom_addr[0] = 1'b0;
         end
      end else begin : g_nofold
         logic unused_lvl;
         assign unused_lvl = tape_lvl;
         assign rom_addr   = low;
      end
   endgenerate
endmodule

// File: rtl/tape_card_rom.sv
module tape_card_rom #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/tape_card_toggle.sv
module tape_card_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (strobe) q <= ~q;
   end
endmodule

// File: rtl/tape_card_if.sv
module tape_card_if
   import tape_card_pkg::*;
#(
   parameter int         ADDR_W      = 16,
   parameter int         DATA_W      = 8,
   parameter int         ROM_AW      = 8,
   parameter logic [3:0] CARD_ID     = 4'hC,
   parameter int         IO_PAGE     = 0,
   parameter int         CODE_PAGE   = 1,
   parameter int         SYNC_STAGES = 2,
   parameter bit         FOLD_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_drive,
   input  logic              tape_in,
   output logic              tape_out,
   input  logic              rom_ld_en,
   input  logic [ROM_AW-1:0] rom_ld_addr,
   input  logic [DATA_W-1:0] rom_ld_data
);
   localparam int PAGE_W = ADDR_W - 4 - ROM_AW;

   generate
      if (PAGE_W < 1) begin : g_bad_w
         $error("address too narrow for card window and ROM page");
      end
      if (IO_PAGE == CODE_PAGE) begin : g_bad_pg
         $error("I/O page and code page must differ");
      end
      if (IO_PAGE >= (1 << PAGE_W) || CODE_PAGE >= (1 << PAGE_W)) begin : g_bad_rng
         $error("page index outside card window");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchroniser depth out of range");
      end
   endgenerate

   logic              tape_lvl;
   tc_sel_t           sel;
   logic [ROM_AW-1:0] rom_addr;
   logic              req_q;
   logic              first_cyc;
   logic              rd_hit;

   tape_card_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(tape_in), .d_sync(tape_lvl)
   );

   tape_card_decode #(
      .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .CARD_ID(CARD_ID),
      .IO_PAGE(IO_PAGE), .CODE_PAGE(CODE_PAGE), .FOLD_EN(FOLD_EN)
   ) u_dec (
      .addr(bus_addr), .tape_lvl(tape_lvl), .sel(sel), .rom_addr(rom_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= bus_req;
   end

   assign first_cyc = bus_req && !req_q;
   assign rd_hit    = bus_req && !bus_we && (sel.io_page || sel.code_page);

   tape_card_rom #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
      .clk(clk), .rd_en(rd_hit), .rd_addr(rom_addr), .rd_data(bus_rdata),
      .ld_en(rom_ld_en), .ld_addr(rom_ld_addr), .ld_data(rom_ld_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_drive <= 1'b0;
      else        bus_drive <= rd_hit;
   end

   tape_card_toggle u_tog (
      .clk(clk), .rst_n(rst_n), .strobe(first_cyc && sel.io_page), .q(tape_out)
   );
endmodule

// File: rtl/tape_card_if_chk.sv
module tape_card_if_chk #(
   parameter int         ADDR_W = 16,
   parameter logic [3:0] CARD_ID = 4'hC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_drive,
   input logic              tape_out
);
   logic req_d;
   logic ok_page;
   logic io_pg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= bus_req;
   end

   assign io_pg   = (bus_addr[ADDR_W-1 -: 4] == CARD_ID) && (bus_addr[ADDR_W-5:8] == '0);
   assign ok_page = (bus_addr[ADDR_W-1 -: 4] == CARD_ID) && (bus_addr[ADDR_W-5:9] == '0);

   assert_reset_quiet_R7: assert property (@(posedge clk)
      !rst_n |=> (!tape_out && !bus_drive));

   assert_drive_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> $past(bus_req && !bus_we && ok_page));

   assert_write_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |=> !bus_drive);

   assert_toggle_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tape_out != $past(tape_out)) |-> $past(bus_req && !req_d && io_pg));

   assert_held_no_retoggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && req_d) |=> $stable(tape_out));
endmodule

bind tape_card_if tape_card_if_chk #(.ADDR_W(ADDR_W), .CARD_ID(CARD_ID)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_drive(bus_drive), .tape_out(tape_out)
);

// File: tb/tape_card_if_bench.sv
module tape_card_if_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_rdata;
   logic        bus_drive;
   logic        tape_in = 1'b0;
   logic        tape_out;
   logic        rom_ld_en = 1'b0;
   logic [7:0]  rom_ld_addr = '0;
   logic [7:0]  rom_ld_data = '0;

   int tests = 0;
   int fails = 0;
   logic [7:0] img [256];
   logic [7:0] exp_q [$];
   logic       tog_exp = 1'b0;
   logic       monitor_on = 1'b0;

   always #5 clk = ~clk;

   tape_card_if u_tape_card_if (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_drive(bus_drive),
      .tape_in(tape_in), .tape_out(tape_out), .rom_ld_en(rom_ld_en),
      .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected byte for every driven cycle
   always begin
      @(posedge clk);
      #2;
      if (monitor_on && bus_drive) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected drive", 1, 0);
         end else begin
            check("R2/R3/R4/R9 read data", {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   // driver: holds an access for n cycles, pushes expected read bytes
   task automatic access(input logic [15:0] a, input logic we, input int n,
                         input logic [7:0] e, input logic drives);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_req = 1'b1;
      if (drives) for (int i = 0; i < n; i++) exp_q.push_back(e);
      if (a[15:8] == 8'hC0) tog_exp = ~tog_exp;
      repeat (n) @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      @(negedge clk);
      check("R9 queue drained", exp_q.size(), 0);
      check("R5 tape_out", {31'h0, tape_out}, {31'h0, tog_exp});
   endtask

   function automatic logic [7:0] folded(input logic [7:0] lo, input logic lvl);
      return (lo[7] && lvl) ? img[{lo[7:1], 1'b0}] : img[lo];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) img[i] = 8'((i * 37 + 11) ^ (i >> 3));
      repeat (3) @(negedge clk);
      check("R7 tape_out in reset", {31'h0, tape_out}, 0);
      check("R7 drive in reset", {31'h0, bus_drive}, 0);
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         rom_ld_en = 1'b1; rom_ld_addr = 8'(i); rom_ld_data = img[i];
      end
      @(negedge clk);
      rom_ld_en = 1'b0;
      rst_n = 1'b1;
      monitor_on = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 tape_out after reset", {31'h0, tape_out}, 0);

      // R2 code page reads
      access(16'hC100, 0, 1, img[8'h00], 1);
      access(16'hC181, 0, 1, img[8'h81], 1);
      access(16'hC1FF, 0, 1, img[8'hFF], 1);
      // R3 lower I/O half ignores the input
      tape_in = 1'b1; repeat (4) @(negedge clk);
      access(16'hC041, 0, 1, img[8'h41], 1);
      tape_in = 1'b0; repeat (4) @(negedge clk);
      access(16'hC041, 0, 1, img[8'h41], 1);
      access(16'hC07F, 0, 1, img[8'h7F], 1);
      // R4 upper I/O half folds bit 0 on a high input
      access(16'hC081, 0, 1, folded(8'h81, 0), 1);
      tape_in = 1'b1; repeat (4) @(negedge clk);
      access(16'hC081, 0, 1, folded(8'h81, 1), 1);
      access(16'hC0FF, 0, 1, folded(8'hFF, 1), 1);
      access(16'hC0A6, 0, 1, folded(8'hA6, 1), 1);
      // R8 first read after a change sees the old level
      tape_in = 1'b0;
      access(16'hC081, 0, 1, img[8'h80], 1);
      repeat (3) @(negedge clk);
      access(16'hC081, 0, 1, img[8'h81], 1);
      // R5 held access toggles once; R9 data refreshed each held cycle
      access(16'hC081, 0, 4, img[8'h81], 1);
      access(16'hC010, 1, 3, 8'h00, 0);
      access(16'hC120, 1, 2, 8'h00, 0);
      // R6 write to ROM space leaves contents intact
      access(16'hC120, 0, 1, img[8'h20], 1);
      // R1 outside window / other pages
      access(16'hC200, 0, 1, 8'h00, 0);
      access(16'hD081, 0, 1, 8'h00, 0);
      access(16'h4100, 0, 2, 8'h00, 0);
      access(16'hCF00, 1, 1, 8'h00, 0);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule